// File: doc/BRIEF.md
# Audio Link Interrupt and DMA-Request Controller

This block collects FIFO event pulses from the two directions of an audio sample link. One direction is playback, from memory towards the converter. The other is capture, from the converter towards memory. The events are held in a sticky status register, and one level-sensitive interrupt line is driven from the enabled events. The block also drives one DMA-request line per direction by comparing the FIFO fill level against a programmable threshold.

Software reaches the block through a plain 32-bit register port: write strobe, byte address, write data, and combinational read data.

Interrupt enables and DMA enables never take a plain write. Each has a pair of registers: writing a one to the first sets the matching bit, and writing a one to the second clears it. Software reads the masked status and acknowledges by writing that same value back.

Each direction also has a soft reset, held by a control bit. The soft reset empties that direction's status and silences its DMA request without disturbing the other direction.

Top module: `audio_irq_dma_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq`, `pb_dma_req` and `cap_dma_req` are low.
- R2: An event pulse sets its latched status bit on the next clock edge and the bit stays set. Playback events go to bits 0..3 in the order request, empty, almost-empty, full. Capture events go to bits 8..11 in the order request, empty, almost-full, full. The raw status is read at byte address 0x24.
- R3: A write of ones to address 0x2C sets those interrupt-enable bits, and a write of ones to 0x30 clears them. Zero bits leave the enables unchanged. Both addresses read back the current enables.
- R4: Address 0x28 reads the raw status ANDed with the interrupt enables. `irq` is high exactly when that masked value is non-zero.
- R5: Writing to 0x28 clears each latched status bit written as one and leaves every other bit unchanged.
- R6: If an event pulse arrives in the same cycle as a write-one clear of its bit, the bit stays set.
- R7: Bit 0 (playback) and bit 1 (capture) of the DMA enable are set by writing ones to 0x38 and cleared by writing ones to 0x3C. Both addresses read back the enable. With its enable clear, a direction's DMA request stays low.
- R8: `pb_dma_req` is high when the playback enable is on, the playback soft reset is off, and `pb_level` is at or below the playback threshold.
- R9: `cap_dma_req` is high when the capture enable is on, the capture soft reset is off, and `cap_level` is at or above the capture threshold.
- R10: While control bit 12 (at 0x44) is set, status bits 0..3 read 0 and `pb_dma_req` is low. Capture bits and the capture request are unaffected.
- R11: While control bit 11 is set, status bits 8..11 read 0 and `cap_dma_req` is low. Playback bits and the playback request are unaffected.
- R12: The playback threshold (0x50) and the capture threshold (0x54) each hold data bits 3:0, so the largest threshold is 15. Higher data bits are dropped.
- R13: Writes to 0x24 have no effect. In every event or enable register, bits outside 0..3 and 8..11 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pb_evt | input | 4 | Playback event pulses: request, empty, almost-empty, full |
| cap_evt | input | 4 | Capture event pulses: request, empty, almost-full, full |
| pb_level | input | LVL_W | Playback FIFO fill level |
| cap_level | input | LVL_W | Capture FIFO fill level |
| irq | output | 1 | Interrupt request |
| pb_dma_req | output | 1 | Playback DMA request |
| cap_dma_req | output | 1 | Capture DMA request |

## Verification
The bench builds the block with its defaults: a 5-bit FIFO level and a 4-bit threshold. A level can therefore exceed the largest threshold. Playback levels of 16 and above must never raise a request, and a capture threshold of 0 keeps the capture request high at every level. Both extremes are driven, together with levels one below, at and one above each programmed threshold. The stimulus also lands a clear on the same edge as a new event, and holds one soft reset while the other direction keeps receiving events.

// File: rtl/audio_irq_dma_ctrl.sv
module audio_irq_dma_ctrl #(
  parameter int LVL_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [3:0]       pb_evt,
  input  logic [3:0]       cap_evt,
  input  logic [LVL_W-1:0] pb_level,
  input  logic [LVL_W-1:0] cap_level,
  output logic             irq,
  output logic             pb_dma_req,
  output logic             cap_dma_req
);
  localparam logic [11:0] EVT_MASK = 12'hF0F;
  localparam logic [7:0] A_RAW = 8'h24, A_MSK = 8'h28, A_IES = 8'h2C, A_IEC = 8'h30,
                         A_WAKE = 8'h34, A_DMS = 8'h38, A_DMC = 8'h3C, A_DWAKE = 8'h40,
                         A_CTRL = 8'h44, A_THP = 8'h50, A_THC = 8'h54;
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [11:0] raw_q, ien_q, wake_q;
  logic [1:0]  dma_q, dwake_q;
  logic [12:0] ctrl_q;
  logic [THR_W-1:0] thr_pb_q, thr_cap_q;

  wire pb_rst  = ctrl_q[12];
  wire cap_rst = ctrl_q[11];
  wire [11:0] wmask = bus_wdata[11:0] & EVT_MASK;
  wire [11:0] evt_vec = {cap_evt, 4'b0000, pb_evt};
  wire [11:0] ack = (bus_we && bus_addr == A_MSK) ? wmask : 12'h000;
  wire [11:0] hold = ~{{4{cap_rst}}, 4'b0000, {4{pb_rst}}};
  wire [11:0] raw_d = ((raw_q & ~ack) | evt_vec) & hold;
  wire [11:0] masked = raw_q & ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0; ien_q <= '0; wake_q <= '0;
      dma_q <= '0; dwake_q <= '0; ctrl_q <= '0;
      thr_pb_q <= '0; thr_cap_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (bus_we) begin
        case (bus_addr)
          A_IES:   ien_q <= ien_q | wmask;
          A_IEC:   ien_q <= ien_q & ~wmask;
          A_WAKE:  wake_q <= wmask;
          A_DMS:   dma_q <= dma_q | bus_wdata[1:0];
          A_DMC:   dma_q <= dma_q & ~bus_wdata[1:0];
          A_DWAKE: dwake_q <= bus_wdata[1:0];
          A_CTRL:  ctrl_q <= bus_wdata[12:0];
          A_THP:   thr_pb_q <= bus_wdata[THR_W-1:0];
          A_THC:   thr_cap_q <= bus_wdata[THR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_RAW:        bus_rdata = {20'd0, raw_q};
      A_MSK:        bus_rdata = {20'd0, masked};
      A_IES, A_IEC: bus_rdata = {20'd0, ien_q};
      A_WAKE:       bus_rdata = {20'd0, wake_q};
      A_DMS, A_DMC: bus_rdata = {30'd0, dma_q};
      A_DWAKE:      bus_rdata = {30'd0, dwake_q};
      A_CTRL:       bus_rdata = {19'd0, ctrl_q};
      A_THP:        bus_rdata = 32'(thr_pb_q);
      A_THC:        bus_rdata = 32'(thr_cap_q);
      default:      bus_rdata = 32'd0;
    endcase
  end

  assign irq         = |masked;
  assign pb_dma_req  = dma_q[0] & ~pb_rst  & (CMP_W'(pb_level)  <= CMP_W'(thr_pb_q));
  assign cap_dma_req = dma_q[1] & ~cap_rst & (CMP_W'(cap_level) >= CMP_W'(thr_cap_q));
endmodule

// File: rtl/audio_irq_dma_ctrl_chk.sv
module audio_irq_dma_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  pb_evt,
  input logic [3:0]  cap_evt,
  input logic [11:0] raw,
  input logic [11:0] ien,
  input logic [1:0]  dma,
  input logic [12:0] ctrl,
  input logic        irq,
  input logic        pb_req,
  input logic        cap_req
);
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_evt && !ctrl[11]) |=> ((raw[11:8] & $past(cap_evt)) == $past(cap_evt)));
  p_ien_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h2C) |=>
      ((ien & ($past(bus_wdata[11:0]) & 12'hF0F)) == ($past(bus_wdata[11:0]) & 12'hF0F)));
  p_ien_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h30) |=> ((ien & $past(bus_wdata[11:0])) == 12'h000));
  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & ien) != 12'h000));
  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 12'h000) |-> !irq);
  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_evt[0] && !ctrl[12] && bus_we && bus_addr == 8'h28 && bus_wdata[0]) |=> raw[0]);
  p_dma_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma[0] |-> !pb_req) and (!dma[1] |-> !cap_req));
  p_pb_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[12] |=> (raw[3:0] == 4'h0));
  p_pb_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[12] |-> !pb_req);
  p_cap_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[11] |=> (raw[11:8] == 4'h0));
  p_cap_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[11] |-> !cap_req);
endmodule

bind audio_irq_dma_ctrl audio_irq_dma_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pb_evt(pb_evt), .cap_evt(cap_evt), .raw(raw_q), .ien(ien_q), .dma(dma_q),
  .ctrl(ctrl_q), .irq(irq), .pb_req(pb_dma_req), .cap_req(cap_dma_req)
);

// File: tb/audio_irq_dma_ctrl_test.sv
`timescale 1ns/1ps
module audio_irq_dma_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic [3:0] pb_evt = 4'd0, cap_evt = 4'd0;
  logic [4:0] pb_level = 5'd0, cap_level = 5'd0;
  logic irq, pb_dma_req, cap_dma_req;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit done = 0;

  int m_raw, m_ien, m_wake, m_dma, m_dwk, m_ctrl, m_thp, m_thc;
  int clr, nraw;

  always #2.5 clk = ~clk;

  audio_irq_dma_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pb_evt(pb_evt), .cap_evt(cap_evt), .pb_level(pb_level),
    .cap_level(cap_level), .irq(irq), .pb_dma_req(pb_dma_req), .cap_dma_req(cap_dma_req)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_ien = 0; m_wake = 0; m_dma = 0; m_dwk = 0; m_ctrl = 0; m_thp = 0; m_thc = 0;
    end else begin
      clr = (bus_we && bus_addr == 8'h28) ? (int'(bus_wdata) & 'hF0F) : 0;
      nraw = (m_raw & ~clr) | (int'(cap_evt) << 8) | int'(pb_evt);
      if ((m_ctrl & 'h1000) != 0) nraw = nraw & ~'hF;
      if ((m_ctrl & 'h800) != 0) nraw = nraw & ~'hF00;
      m_raw = nraw;
      if (bus_we) begin
        case (bus_addr)
          8'h2C: m_ien = m_ien | (int'(bus_wdata) & 'hF0F);
          8'h30: m_ien = m_ien & ~(int'(bus_wdata) & 'hF0F);
          8'h34: m_wake = int'(bus_wdata) & 'hF0F;
          8'h38: m_dma = m_dma | (int'(bus_wdata) & 3);
          8'h3C: m_dma = m_dma & ~(int'(bus_wdata) & 3);
          8'h40: m_dwk = int'(bus_wdata) & 3;
          8'h44: m_ctrl = int'(bus_wdata) & 'h1FFF;
          8'h50: m_thp = int'(bus_wdata) & 'hF;
          8'h54: m_thc = int'(bus_wdata) & 'hF;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(input logic [7:0] a);
    case (a)
      8'h24: return m_raw;
      8'h28: return m_raw & m_ien;
      8'h2C, 8'h30: return m_ien;
      8'h34: return m_wake;
      8'h38, 8'h3C: return m_dma;
      8'h40: return m_dwk;
      8'h44: return m_ctrl;
      8'h50: return m_thp;
      8'h54: return m_thc;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h (t=%0t)", phase, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk($sformatf("rdata@%0h", bus_addr), int'(bus_rdata), exp_rd(bus_addr));
      chk("irq", int'(irq), int'((m_raw & m_ien) != 0));
      chk("pb_dma_req", int'(pb_dma_req),
          int'((m_dma & 1) != 0 && (m_ctrl & 'h1000) == 0 && int'(pb_level) <= m_thp));
      chk("cap_dma_req", int'(cap_dma_req),
          int'((m_dma & 2) != 0 && (m_ctrl & 'h800) == 0 && int'(cap_level) >= m_thc));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] p, input logic [3:0] c);
    @(negedge clk); pb_evt = p; cap_evt = c;
    @(negedge clk); pb_evt = 4'd0; cap_evt = 4'd0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";
    foreach (exp_addrs[i]) rd(exp_addrs[i]);
    phase = "R12";
    wr(8'h50, 32'h37); wr(8'h54, 32'hFA); rd(8'h50); rd(8'h54);
    phase = "R3";
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C); wr(8'h30, 32'h0000_0102); rd(8'h30); rd(8'h2C);
    phase = "R2";
    bus_addr = 8'h24; pulse(4'b1010, 4'b0101); rd(8'h24); pulse(4'b0101, 4'b1010); rd(8'h24);
    phase = "R4";
    rd(8'h28); wr(8'h30, 32'hF0F); rd(8'h28); wr(8'h2C, 32'h00F); rd(8'h28);
    phase = "R13";
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24); wr(8'h2C, 32'h0000_F0F0); rd(8'h2C); wr(8'h34, 32'hFFFF); rd(8'h34);
    phase = "R5";
    wr(8'h28, 32'h008); rd(8'h24); wr(8'h28, 32'hFFF); rd(8'h24); rd(8'h28);
    phase = "R6";
    @(negedge clk); pb_evt = 4'b0001; bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h1;
    @(negedge clk); pb_evt = 4'd0; bus_we = 1'b0; bus_addr = 8'h24;
    @(negedge clk);
    phase = "R7";
    pb_level = 5'd0; cap_level = 5'd31;
    wr(8'h38, 32'h3); rd(8'h38); wr(8'h3C, 32'h1); rd(8'h3C); wr(8'h3C, 32'h2); wr(8'h38, 32'h1);
    phase = "R8";
    for (int l = 5; l <= 9; l++) begin @(negedge clk); pb_level = 5'(l); end
    for (int l = 15; l <= 31; l += 8) begin @(negedge clk); pb_level = 5'(l); end
    wr(8'h50, 32'hF); @(negedge clk); pb_level = 5'd15; @(negedge clk); pb_level = 5'd16;
    @(negedge clk); pb_level = 5'd3;
    phase = "R9";
    wr(8'h38, 32'h2);
    for (int l = 8; l <= 12; l++) begin @(negedge clk); cap_level = 5'(l); end
    wr(8'h54, 32'h0); @(negedge clk); cap_level = 5'd0; @(negedge clk); wr(8'h54, 32'hA);
    phase = "R10";
    wr(8'h44, 32'h1000); bus_addr = 8'h24; pulse(4'hF, 4'hF); rd(8'h24); rd(8'h44);
    wr(8'h44, 32'h0); pulse(4'h3, 4'h0); rd(8'h24);
    phase = "R11";
    wr(8'h44, 32'h0800); bus_addr = 8'h24; pulse(4'hC, 4'hF); rd(8'h24); rd(8'h28);
    wr(8'h44, 32'h1800); rd(8'h24); wr(8'h44, 32'h0); pulse(4'h0, 4'h9); rd(8'h24);
    phase = "R5 mixed";
    lf = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      @(negedge clk);
      pb_evt = (lf[3:0] & {4{lf[20]}});
      cap_evt = (lf[7:4] & {4{lf[21]}});
      pb_level = lf[12:8]; cap_level = lf[17:13];
      bus_we = lf[22] & lf[23];
      bus_addr = exp_addrs[lf[27:24] % 11];
      bus_wdata = {lf[15:0], lf[31:16]} & ((lf[28] && bus_addr == 8'h44) ? 32'h0 : 32'hFFFF_FFFF);
    end
    @(negedge clk); bus_we = 1'b0; pb_evt = 4'd0; cap_evt = 4'd0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  logic [7:0] exp_addrs [11] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38,
                                 8'h3C, 8'h40, 8'h44, 8'h50, 8'h54};
endmodule